// File: doc/BRIEF.md
# Half-Zigzag Scan Address Sequencer

This block walks an 8x8 pixel map in the half-zigzag order used when coefficients are scanned diagonally. It covers the upper-left triangle from the corner at (1,1) to the top-right corner at (8,1). Coordinates are 1-based. The order is not held in a table. Four step-vector moves produce it: east (+1,0), south (0,+1), north-east (+1,-1) and south-west (-1,+1). Each diagonal move repeats its vector up to a bounded count and leaves as soon as it reaches its boundary row or column.

A start pulse on an idle or finished block begins the walk. Addresses leave on a valid/ready stream. Each address carries x, y and a linear index (y-1)*8+(x-1). An address is consumed in a cycle where valid and ready are both high. While ready is low, valid, the address and the last flag hold, so nothing is skipped or repeated. The final address is flagged with last. After it is consumed, valid drops and done rises. Done stays high until the next start is accepted.

Top module: `zz_scan_seq`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid, out_last and done are all 0.
- R2: A start pulse seen while out_valid is 0 makes out_valid 1 one cycle later, showing x=1, y=1, out_addr=0 and done=0.
- R3: Consumed addresses follow this order, 29 in all: one east move; then three groups, each made of a south-west diagonal, one south step, a north-east diagonal and one east step.
- R4: Two consecutive addresses differ by exactly one of the vectors (+1,0), (0,+1), (+1,-1) or (-1,+1).
- R5: A diagonal move checks its boundary before every step. South-west stops once x is 1 and north-east stops once y is 1, and neither runs more than 8 steps. A diagonal that begins on its boundary makes no step.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_x, out_y, out_addr and out_last stay unchanged.
- R7: out_last is 1 only together with the final address (8,1), and for no other address.
- R8: Consuming the last address makes out_valid 0 and done 1 in the next cycle. Done then stays 1 until a start is accepted.
- R9: A start pulse while out_valid is 1 is ignored. The walk continues with the next address in order.
- R10: out_addr always equals (out_y-1)*8+(out_x-1) while out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a walk when no address is pending |
| out_ready | input | 1 | Consumer accepts the current address |
| out_valid | output | 1 | An address is presented |
| out_x | output | 4 | Column, 1 to 8 |
| out_y | output | 4 | Row, 1 to 8 |
| out_addr | output | 6 | Linear index (y-1)*8+(x-1) |
| out_last | output | 1 | Presented address is the final one |
| done | output | 1 | Walk finished, held until next start |

## Verification
Two events can land on the same clock edge: the final address being consumed, and a fresh start pulse. The bench raises start in exactly the cycle where the last address is taken. It then expects valid low and done high on the next cycle, with no restart at (1,1). A separate start is needed afterwards to begin a new walk. Start is also raised mid-walk, during a consumed cycle, and a stall is placed on the last address itself. Both must leave the expected order intact.

// File: rtl/zz_scan_pkg.sv
package zz_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EAST0,
    ST_SW,
    ST_SOUTH,
    ST_NE,
    ST_EAST,
    ST_DONE
  } zz_state_e;
endpackage

// File: rtl/zz_move_planner.sv
// Combinational planner: given the move about to be taken and the present
// address, computes the next address and which move follows it.
module zz_move_planner import zz_scan_pkg::*; #(
  parameter int GROUPS   = 3,
  parameter int DIAG_MAX = 8,
  parameter int CW       = 4,
  parameter int SW_W     = 4,
  parameter int GW       = 2
) (
  input  zz_state_e         cur_state,
  input  logic [CW-1:0]     cur_x,
  input  logic [CW-1:0]     cur_y,
  input  logic [SW_W-1:0]   step_cnt,
  input  logic [GW-1:0]     grp_cnt,
  output logic [CW-1:0]     nxt_x,
  output logic [CW-1:0]     nxt_y,
  output zz_state_e         nxt_state,
  output logic [SW_W-1:0]   nxt_step,
  output logic [GW-1:0]     nxt_grp,
  output logic              nxt_last
);
  localparam logic [CW-1:0]   ONE_C   = CW'(1);
  localparam logic [SW_W-1:0] DMAX    = SW_W'(DIAG_MAX);
  localparam logic [GW-1:0]   GRP_END = GW'(GROUPS - 1);

  always_comb begin
    nxt_x     = cur_x;
    nxt_y     = cur_y;
    nxt_state = cur_state;
    nxt_step  = step_cnt;
    nxt_grp   = grp_cnt;
    case (cur_state)
      ST_EAST0: begin
        nxt_x     = cur_x + ONE_C;
        nxt_step  = '0;
        // entering a diagonal already on its boundary skips it
        nxt_state = (nxt_x == ONE_C) ? ST_SOUTH : ST_SW;
      end
      ST_SW: begin
        nxt_x    = cur_x - ONE_C;
        nxt_y    = cur_y + ONE_C;
        nxt_step = step_cnt + SW_W'(1);
        if (nxt_x == ONE_C || nxt_step == DMAX) begin
          nxt_state = ST_SOUTH;
          nxt_step  = '0;
        end
      end
      ST_SOUTH: begin
        nxt_y     = cur_y + ONE_C;
        nxt_step  = '0;
        nxt_state = (nxt_y == ONE_C) ? ST_EAST : ST_NE;
      end
      ST_NE: begin
        nxt_x    = cur_x + ONE_C;
        nxt_y    = cur_y - ONE_C;
        nxt_step = step_cnt + SW_W'(1);
        if (nxt_y == ONE_C || nxt_step == DMAX) begin
          nxt_state = ST_EAST;
          nxt_step  = '0;
        end
      end
      ST_EAST: begin
        nxt_x    = cur_x + ONE_C;
        nxt_step = '0;
        if (grp_cnt == GRP_END) begin
          nxt_state = ST_DONE;
        end else begin
          nxt_grp   = grp_cnt + GW'(1);
          nxt_state = (nxt_x == ONE_C) ? ST_SOUTH : ST_SW;
        end
      end
      default: ;
    endcase
    nxt_last = (nxt_state == ST_DONE);
  end
endmodule

// File: rtl/zz_coord_regs.sv
// Output stage: registered address, linear index, valid and last flags.
module zz_coord_regs #(
  parameter int DIM = 8,
  parameter int CW  = 4,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          advance,
  input  logic [CW-1:0] nxt_x,
  input  logic [CW-1:0] nxt_y,
  input  logic          nxt_last,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic [AW-1:0] lin,
  output logic          valid,
  output logic          last
);
  logic [AW-1:0] lin_nxt;

  always_comb begin
    lin_nxt = AW'((32'(nxt_y) - 32'd1) * 32'(DIM) + 32'(nxt_x) - 32'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x     <= CW'(1);
      y     <= CW'(1);
      lin   <= '0;
      valid <= 1'b0;
      last  <= 1'b0;
    end else if (load) begin
      x     <= CW'(1);
      y     <= CW'(1);
      lin   <= '0;
      valid <= 1'b1;
      last  <= 1'b0;
    end else if (advance) begin
      if (last) begin
        valid <= 1'b0;
        last  <= 1'b0;
      end else begin
        x    <= nxt_x;
        y    <= nxt_y;
        lin  <= lin_nxt;
        last <= nxt_last;
      end
    end
  end

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !advance) |=> (valid && $stable(x) && $stable(y) && $stable(lin) && $stable(last)));

  assert_linear_index_R10: assert property (@(posedge clk) disable iff (rst)
    valid |-> (32'(lin) == (32'(y) - 32'd1) * 32'(DIM) + 32'(x) - 32'd1));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !last) |=> (valid &&
      ((x == $past(x) + CW'(1) && y == $past(y)) ||
       (x == $past(x) && y == $past(y) + CW'(1)) ||
       (x == $past(x) + CW'(1) && y + CW'(1) == $past(y)) ||
       (x + CW'(1) == $past(x) && y == $past(y) + CW'(1)))));

  assert_first_corner_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (valid && x == CW'(1) && y == CW'(1) && lin == '0));
endmodule

// File: rtl/zz_scan_seq.sv
module zz_scan_seq import zz_scan_pkg::*; #(
  parameter int DIM      = 8,
  parameter int GROUPS   = 3,
  parameter int DIAG_MAX = 8,
  localparam int CW      = $clog2(DIM + 1),
  localparam int AW      = $clog2(DIM * DIM),
  localparam int SW_W    = $clog2(DIAG_MAX + 1),
  localparam int GW      = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [CW-1:0] out_x,
  output logic [CW-1:0] out_y,
  output logic [AW-1:0] out_addr,
  output logic          out_last,
  output logic          done
);
  localparam int FINAL_X = 2 * GROUPS + 2;

  zz_state_e        state, nxt_state;
  logic [SW_W-1:0]  step_cnt, nxt_step;
  logic [GW-1:0]    grp_cnt, nxt_grp;
  logic [CW-1:0]    nxt_x, nxt_y;
  logic             nxt_last;
  logic             handshake, load;

  assign handshake = out_valid & out_ready;
  assign load      = start & ~out_valid;

  zz_move_planner #(
    .GROUPS(GROUPS), .DIAG_MAX(DIAG_MAX), .CW(CW), .SW_W(SW_W), .GW(GW)
  ) u_plan (
    .cur_state(state), .cur_x(out_x), .cur_y(out_y),
    .step_cnt(step_cnt), .grp_cnt(grp_cnt),
    .nxt_x(nxt_x), .nxt_y(nxt_y), .nxt_state(nxt_state),
    .nxt_step(nxt_step), .nxt_grp(nxt_grp), .nxt_last(nxt_last)
  );

  zz_coord_regs #(.DIM(DIM), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .load(load), .advance(handshake),
    .nxt_x(nxt_x), .nxt_y(nxt_y), .nxt_last(nxt_last),
    .x(out_x), .y(out_y), .lin(out_addr), .valid(out_valid), .last(out_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
      grp_cnt  <= '0;
      done     <= 1'b0;
    end else if (load) begin
      state    <= ST_EAST0;
      step_cnt <= '0;
      grp_cnt  <= '0;
      done     <= 1'b0;
    end else if (handshake) begin
      state    <= nxt_state;
      step_cnt <= nxt_step;
      grp_cnt  <= nxt_grp;
      if (out_last) done <= 1'b1;
    end
  end

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  assert_last_at_corner_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (out_x == CW'(FINAL_X) && out_y == CW'(1)));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && start && !out_ready) |=> ($stable(state) && $stable(grp_cnt)));

  assert_diag_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && state == ST_SW) |-> (out_x != CW'(1)));
endmodule

// File: tb/zz_scan_seq_test.sv
module zz_scan_seq_test;
  logic       clk = 1'b0;
  logic       rst, start, out_ready;
  logic       out_valid, out_last, done;
  logic [3:0] out_x, out_y;
  logic [5:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam int NADDR = 29;
  localparam int EXP_X [NADDR] = '{1,2, 1,1,2,3,4, 3,2,1,1,2,3,4,5,6,
                                   5,4,3,2,1,1,2,3,4,5,6,7,8};
  localparam int EXP_Y [NADDR] = '{1,1, 2,3,2,1,1, 2,3,4,5,4,3,2,1,1,
                                   2,3,4,5,6,7,6,5,4,3,2,1,1};

  always #4 clk = ~clk;

  zz_scan_seq uut (
    .clk(clk), .rst(rst), .start(start), .out_ready(out_ready),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
    .out_addr(out_addr), .out_last(out_last), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_addr(input int i, input string tag);
    int ex, ey;
    ex = EXP_X[i];
    ey = EXP_Y[i];
    check(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
    check(int'(out_x) == ex, {tag, " R3 x"}, int'(out_x), ex);
    check(int'(out_y) == ey, {tag, " R3 y"}, int'(out_y), ey);
    check(int'(out_addr) == (ey - 1) * 8 + ex - 1, {tag, " R10 addr"},
          int'(out_addr), (ey - 1) * 8 + ex - 1);
    check(out_last == (i == NADDR - 1), {tag, " R7 last"}, int'(out_last),
          (i == NADDR - 1) ? 1 : 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int px, py;
    rst = 1'b1; start = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    check(out_last == 1'b0, "R1 last", int'(out_last), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && done == 1'b0, "R1 after release", int'(out_valid), 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done", int'(done), 0);
    px = 0; py = 0;

    for (int i = 0; i < NADDR; i++) begin
      if (i % 6 == 3 || i == NADDR - 1) begin
        out_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_addr(i, "R6 stall");
      end
      check_addr(i, "walk");
      if (i > 0) begin
        int dx, dy;
        dx = int'(out_x) - px;
        dy = int'(out_y) - py;
        check((dx == 1 && dy == 0) || (dx == 0 && dy == 1) ||
              (dx == 1 && dy == -1) || (dx == -1 && dy == 1),
              "R4 step vector", dx * 10 + dy, 10);
        if (px == 1) check(dx >= 0, "R5 sw stop", dx, 0);
        if (py == 1) check(dy >= 0, "R5 ne stop", dy, 0);
      end
      px = int'(out_x);
      py = int'(out_y);
      out_ready = 1'b1;
      // R9: start while busy; on the final address it meets the last handshake
      start = (i == 10 || i == NADDR - 1);
      @(negedge clk);
      start = 1'b0;
    end

    // R8: finished, start coinciding with last handshake was ignored
    check(out_valid == 1'b0, "R8 valid drop", int'(out_valid), 0);
    check(done == 1'b1, "R8 done rise", int'(done), 1);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && out_valid == 1'b0, "R8 done held", int'(done), 1);

    // R2: restart from done
    out_ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done clear", int'(done), 0);
    check_addr(0, "R2 restart");
    out_ready = 1'b1;
    @(negedge clk);
    check_addr(1, "R2 second");
    @(negedge clk);
    check_addr(2, "R5 first sw");

    // R1: reset mid walk
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0 && out_last == 1'b0 && done == 1'b0,
          "R1 mid reset", int'(out_valid), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule